// File: doc/BRIEF.md
# SPI Command-Decoding Configuration Slave

This block is an SPI slave that fronts the configuration space of a radio core. The host lowers the select line and sends a framed command. The first byte is an opcode, and a sequence of bytes specific to that opcode follows it. The commands cover four operations:

- writing a run of configuration registers through a 16-bit address;
- streaming bytes into a 256-byte packet buffer;
- streaming bytes out of that buffer;
- reading or clearing a 16-bit sticky interrupt word, whose bits are set by event inputs from the core.

All SPI pins are synchronised into the system clock domain. The serial clock must therefore run well below the system clock; a ratio of eight or more is assumed.

Writes are not applied while bytes arrive. They are collected in a short staging store. When the select line rises on a byte boundary, the block raises `busy` and replays the staged writes, one per clock. It then drops `busy`, and the host may start the next command. If the select line rises partway through a byte, the whole command is dropped and nothing changes.

Top module: `spi_cmd_slave`

## Requirements
- R1: The SPI runs in mode 0. MOSI is sampled on rising SCK and MISO changes after falling SCK, most significant bit first. MISO returns 0x00 during the opcode byte and the parameter bytes of every command.
- R2: Opcode 0x0D is followed by the address high byte, then the address low byte, then data bytes. An address from REG_BASE to REG_BASE+REG_COUNT-1 writes byte (address-REG_BASE) of `cfg_flat`, at bits [8*i+7:8*i]. Addresses outside that window are dropped.
- R3: Successive data bytes of one register write go to successive addresses.
- R4: Buffer offsets are 8 bits wide. They wrap from 0xFF to 0x00 while bytes stream in or out.
- R5: Opcode 0x0E is followed by an offset byte and then payload bytes that are written from that offset. Opcode 0x1E is followed by an offset byte. The slave then returns a status byte, followed by buffer bytes read from that offset upward.
- R6: In the status byte, bit 0 is 1 when any interrupt flag is set. All other status bits are 0.
- R7: Opcode 0x12 returns a status byte, then interrupt flags [15:8], then flags [7:0]. Both flag bytes come from one snapshot, taken when the status byte is loaded.
- R8: Opcode 0x02 is followed by a 16-bit mask, high byte first. Each 1 bit in the mask clears the matching flag in the first busy cycle. A command that ends before both mask bytes are complete clears nothing.
- R9: A 1 on `irq_evt[i]` sets `irq_flags[i]` at the next clock edge. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: `busy` goes high only after the select line rises on a byte boundary. It stays high for n+1 cycles, where n is the number of staged data bytes. `cfg_flat` and the buffer change only during busy cycles. After reset, `busy`, `irq_flags` and `cfg_flat` are all zero.
- R11: If the select line rises while a byte is incomplete, the command is aborted. No register, buffer byte or flag changes, and `busy` does not rise.
- R12: An unknown opcode has no effect. The rest of its bytes are consumed, MISO stays 0, and `busy` is high for exactly one cycle.
- R13: A write command stages at most STAGE_DEPTH data bytes. Any data bytes after that are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_nss | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while a finished command is applied |
| irq_evt | input | 16 | Interrupt event pulses from the core |
| irq_flags | output | 16 | Sticky interrupt flags |
| cfg_flat | output | REG_COUNT*8 | Configuration register contents, byte i at [8*i+7:8*i] |

## Verification
An interrupt event and a flag clear can land on the same flag in the same clock. The clear is applied in the first busy cycle after a clear command. To provoke the collision, the bench waits for `busy` to rise after sending the clear mask, then pulses the event for the same bit in that exact cycle. The reference model applies the clear first and the set second, so the flag must stay 1. The bench compares the model with `irq_flags` on every clock, and a read-back command then confirms the flag.

// File: rtl/spi_cmd_slave_pkg.sv
package spi_cmd_slave_pkg;

    localparam int FLAG_W = 16;
    localparam int BUF_AW = 8;

    localparam logic [7:0] OPC_REG_WR = 8'h0D;
    localparam logic [7:0] OPC_BUF_WR = 8'h0E;
    localparam logic [7:0] OPC_BUF_RD = 8'h1E;
    localparam logic [7:0] OPC_FLG_RD = 8'h12;
    localparam logic [7:0] OPC_FLG_CL = 8'h02;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_REG_WR,
        CK_BUF_WR,
        CK_BUF_RD,
        CK_FLG_RD,
        CK_FLG_CL
    } cmd_kind_t;

    typedef enum logic {
        PH_COLLECT,
        PH_APPLY
    } phase_t;

    typedef struct packed {
        logic              reg_we;
        logic [15:0]       reg_addr;
        logic              buf_we;
        logic [BUF_AW-1:0] buf_addr;
        logic [7:0]        data;
    } wr_req_t;

    function automatic cmd_kind_t kind_of(input logic [7:0] opc);
        cmd_kind_t k;
        case (opc)
            OPC_REG_WR: k = CK_REG_WR;
            OPC_BUF_WR: k = CK_BUF_WR;
            OPC_BUF_RD: k = CK_BUF_RD;
            OPC_FLG_RD: k = CK_FLG_RD;
            OPC_FLG_CL: k = CK_FLG_CL;
            default:    k = CK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [7:0] status_of(input logic [FLAG_W-1:0] flags);
        return {7'b0, |flags};
    endfunction

endpackage

// File: rtl/scs_link.sv
module scs_link (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       mosi,
    input  logic       nss,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       tx_load,
    output logic       txn_start,
    output logic       txn_end,
    output logic       txn_abort
);
    logic [2:0] sck_s;
    logic [2:0] nss_s;
    logic [1:0] mosi_s;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;

    logic sck_rise, sck_fall, active;

    assign sck_rise  = sck_s[1] & ~sck_s[2];
    assign sck_fall  = ~sck_s[1] & sck_s[2];
    assign active    = ~nss_s[1];
    assign txn_start = ~nss_s[1] & nss_s[2];
    assign txn_end   = nss_s[1] & ~nss_s[2] & (bit_cnt == 3'd0);
    assign txn_abort = nss_s[1] & ~nss_s[2] & (bit_cnt != 3'd0);
    assign tx_load   = active & sck_fall & (bit_cnt == 3'd0);
    assign miso      = tx_sr[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s  <= 3'b000;
            nss_s  <= 3'b111;
            mosi_s <= 2'b00;
        end else begin
            sck_s  <= {sck_s[1:0], sck};
            nss_s  <= {nss_s[1:0], nss};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (txn_start) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else if (active) begin
                if (sck_rise) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    rx_sr   <= {rx_sr[5:0], mosi_s[1]};
                    if (bit_cnt == 3'd7) begin
                        rx_byte  <= {rx_sr, mosi_s[1]};
                        rx_valid <= 1'b1;
                    end
                end
                if (sck_fall) begin
                    if (tx_load) tx_sr <= tx_byte;
                    else         tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/scs_engine.sv
module scs_engine
    import spi_cmd_slave_pkg::*;
#(
    parameter int STAGE_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_load,
    input  logic              txn_start,
    input  logic              txn_end,
    input  logic [FLAG_W-1:0] flags,
    input  logic [7:0]        buf_rd_data,
    output logic [7:0]        tx_byte,
    output logic [BUF_AW-1:0] buf_rd_addr,
    output wr_req_t           wr,
    output logic              clr_en,
    output logic [FLAG_W-1:0] clr_mask,
    output logic              busy
);
    localparam int SW = $clog2(STAGE_DEPTH + 1);
    localparam int IW = (STAGE_DEPTH > 1) ? $clog2(STAGE_DEPTH) : 1;
    localparam logic [SW-1:0] STAGE_MAX = SW'(STAGE_DEPTH);

    phase_t            phase;
    cmd_kind_t         kind;
    logic [7:0]        seen;
    logic [15:0]       base;
    logic [BUF_AW-1:0] rd_ptr;
    logic [FLAG_W-1:0] mask;
    logic              mask_ok;
    logic [FLAG_W-1:0] snap;
    logic [7:0]        stage [STAGE_DEPTH];
    logic [SW-1:0]     stage_n;
    logic [SW-1:0]     cidx;
    logic              push;

    always_comb begin
        push = 1'b0;
        if (rx_valid && !txn_start && seen >= 8'd3 && kind == CK_REG_WR) push = 1'b1;
        if (rx_valid && !txn_start && seen >= 8'd2 && kind == CK_BUF_WR) push = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push && stage_n < STAGE_MAX) stage[IW'(stage_n)] <= rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind    <= CK_NONE;
            seen    <= '0;
            base    <= '0;
            rd_ptr  <= '0;
            mask    <= '0;
            mask_ok <= 1'b0;
            snap    <= '0;
            stage_n <= '0;
        end else if (txn_start) begin
            kind    <= CK_NONE;
            seen    <= '0;
            stage_n <= '0;
            mask_ok <= 1'b0;
        end else begin
            if (rx_valid) begin
                if (seen != 8'hFF) seen <= seen + 8'd1;
                if (seen == 8'd0) begin
                    kind <= kind_of(rx_byte);
                end else begin
                    case (kind)
                        CK_REG_WR: begin
                            if (seen == 8'd1) base[15:8] <= rx_byte;
                            if (seen == 8'd2) base[7:0]  <= rx_byte;
                        end
                        CK_BUF_WR: if (seen == 8'd1) base <= {8'h00, rx_byte};
                        CK_BUF_RD: if (seen == 8'd1) rd_ptr <= rx_byte;
                        CK_FLG_CL: begin
                            if (seen == 8'd1) mask[15:8] <= rx_byte;
                            if (seen == 8'd2) begin
                                mask[7:0] <= rx_byte;
                                mask_ok   <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (push && stage_n < STAGE_MAX) stage_n <= stage_n + SW'(1);
            end
            if (tx_load && kind == CK_BUF_RD && seen >= 8'd3) rd_ptr <= rd_ptr + 8'd1;
            if (tx_load && kind == CK_FLG_RD && seen == 8'd1) snap <= flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_COLLECT;
            cidx  <= '0;
        end else if (phase == PH_COLLECT) begin
            if (txn_end) begin
                phase <= PH_APPLY;
                cidx  <= '0;
            end
        end else begin
            if (cidx == stage_n) phase <= PH_COLLECT;
            else                 cidx  <= cidx + SW'(1);
        end
    end

    always_comb begin
        tx_byte = 8'h00;
        case (kind)
            CK_BUF_RD: begin
                if (seen == 8'd2)      tx_byte = status_of(flags);
                else if (seen >= 8'd3) tx_byte = buf_rd_data;
            end
            CK_FLG_RD: begin
                if (seen == 8'd1)      tx_byte = status_of(flags);
                else if (seen == 8'd2) tx_byte = snap[15:8];
                else if (seen == 8'd3) tx_byte = snap[7:0];
            end
            default: ;
        endcase
    end

    always_comb begin
        wr          = '0;
        wr.data     = stage[IW'(cidx)];
        wr.reg_addr = base + 16'(cidx);
        wr.buf_addr = base[7:0] + 8'(cidx);
        if (phase == PH_APPLY && cidx < stage_n) begin
            wr.reg_we = (kind == CK_REG_WR);
            wr.buf_we = (kind == CK_BUF_WR);
        end
    end

    assign clr_en      = (phase == PH_APPLY) && (cidx == '0) && (kind == CK_FLG_CL) && mask_ok;
    assign clr_mask    = mask;
    assign buf_rd_addr = rd_ptr;
    assign busy        = (phase == PH_APPLY);
endmodule

// File: rtl/scs_store.sv
module scs_store
    import spi_cmd_slave_pkg::*;
#(
    parameter logic [15:0] REG_BASE  = 16'h06C0,
    parameter int          REG_COUNT = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr,
    input  logic [BUF_AW-1:0]      buf_rd_addr,
    output logic [7:0]             buf_rd_data,
    output logic [REG_COUNT*8-1:0] cfg_flat
);
    localparam int BUF_DEPTH = 1 << BUF_AW;

    logic [7:0] mem [BUF_DEPTH];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        localparam logic [15:0] ADDR = REG_BASE + 16'(i);
        always_ff @(posedge clk) begin
            if (rst)                                   cfg_flat[8*i +: 8] <= 8'h00;
            else if (wr.reg_we && wr.reg_addr == ADDR) cfg_flat[8*i +: 8] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (wr.buf_we) mem[wr.buf_addr] <= wr.data;
    end

    assign buf_rd_data = mem[buf_rd_addr];
endmodule

// File: rtl/scs_flags.sv
module scs_flags
    import spi_cmd_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] evt,
    input  logic              clr_en,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~(clr_en ? clr_mask : '0)) | evt;
    end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_slave_pkg::*;
#(
    parameter logic [15:0] REG_BASE    = 16'h06C0,
    parameter int          REG_COUNT   = 16,
    parameter int          STAGE_DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   spi_sck,
    input  logic                   spi_mosi,
    input  logic                   spi_nss,
    output logic                   spi_miso,
    output logic                   busy,
    input  logic [15:0]            irq_evt,
    output logic [15:0]            irq_flags,
    output logic [REG_COUNT*8-1:0] cfg_flat
);
    logic              rx_valid, tx_load, txn_start, txn_end, txn_abort;
    logic [7:0]        rx_byte, tx_byte, buf_rd_data;
    logic [BUF_AW-1:0] buf_rd_addr;
    logic              clr_en;
    logic [FLAG_W-1:0] clr_mask;
    wr_req_t           wr;

    scs_link link_i (
        .clk(clk), .rst(rst), .sck(spi_sck), .mosi(spi_mosi), .nss(spi_nss),
        .tx_byte(tx_byte), .miso(spi_miso), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_load(tx_load), .txn_start(txn_start), .txn_end(txn_end), .txn_abort(txn_abort)
    );

    scs_engine #(.STAGE_DEPTH(STAGE_DEPTH)) engine_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_load(tx_load),
        .txn_start(txn_start), .txn_end(txn_end), .flags(irq_flags),
        .buf_rd_data(buf_rd_data), .tx_byte(tx_byte), .buf_rd_addr(buf_rd_addr),
        .wr(wr), .clr_en(clr_en), .clr_mask(clr_mask), .busy(busy)
    );

    scs_store #(.REG_BASE(REG_BASE), .REG_COUNT(REG_COUNT)) store_i (
        .clk(clk), .rst(rst), .wr(wr), .buf_rd_addr(buf_rd_addr),
        .buf_rd_data(buf_rd_data), .cfg_flat(cfg_flat)
    );

    scs_flags flags_i (
        .clk(clk), .rst(rst), .evt(irq_evt), .clr_en(clr_en),
        .clr_mask(clr_mask), .flags(irq_flags)
    );

    // An aborted command simply never reaches txn_end; the pulse is not otherwise needed.
    logic abort_seen_unused;
    assign abort_seen_unused = txn_abort;
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
    parameter int STAGE_DEPTH = 16,
    parameter int CFG_W       = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             spi_nss,
    input logic             busy,
    input logic [15:0]      irq_evt,
    input logic [15:0]      irq_flags,
    input logic [CFG_W-1:0] cfg_flat
);
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 32'd1;
        else           busy_run <= '0;
    end

    // R10
    busy_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> spi_nss);

    // R9
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq_flags & $past(irq_evt)) == $past(irq_evt)));

    // R8
    clear_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> ((irq_flags & $past(irq_flags)) == $past(irq_flags)));

    // R10
    cfg_held_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> $stable(cfg_flat));

    // R13
    busy_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run <= 32'(STAGE_DEPTH)));
endmodule

bind spi_cmd_slave scs_checker #(.STAGE_DEPTH(STAGE_DEPTH), .CFG_W(REG_COUNT*8)) chk_i (
    .clk(clk), .rst(rst), .spi_nss(spi_nss), .busy(busy),
    .irq_evt(irq_evt), .irq_flags(irq_flags), .cfg_flat(cfg_flat)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int CNT        = 16;
    localparam int STG        = 16;
    localparam logic [15:0] BASE = 16'h06C0;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_nss = 1'b1;
    logic spi_miso, busy;
    logic [15:0] irq_evt = '0;
    logic [15:0] irq_flags;
    logic [CNT*8-1:0] cfg_flat;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_slave #(.REG_BASE(BASE), .REG_COUNT(CNT), .STAGE_DEPTH(STG)) dut_i (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_nss(spi_nss),
        .spi_miso(spi_miso), .busy(busy), .irq_evt(irq_evt), .irq_flags(irq_flags),
        .cfg_flat(cfg_flat)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    logic [CNT*8-1:0] exp_cfg = '0;
    logic [15:0]      exp_irq = '0;
    logic [7:0]       exp_buf [256];
    int               m_kind = 0;
    logic [15:0]      m_base = '0;
    logic [15:0]      m_mask = '0;
    bq_t              m_data;
    int               run = 0, last_len = 0, nbusy = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial for (int i = 0; i < 256; i++) exp_buf[i] = 8'h00;

    always @(posedge clk) begin
        if (rst) begin
            run = 0;
        end else begin
            if (busy) begin
                if (m_kind == 1 && run < m_data.size()) begin
                    logic [15:0] a;
                    a = m_base + 16'(run);
                    if (a >= BASE && a < BASE + 16'(CNT)) exp_cfg[(a - BASE)*8 +: 8] = m_data[run];
                end
                if (m_kind == 2 && run < m_data.size()) exp_buf[8'(m_base + 16'(run))] = m_data[run];
                if (m_kind == 3 && run == 0) exp_irq = exp_irq & ~m_mask;
                run++;
            end else if (run > 0) begin
                last_len = run;
                run = 0;
                nbusy++;
            end
            exp_irq = exp_irq | irq_evt;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks += 2;
            if (cfg_flat !== exp_cfg) begin
                fails++;
                $display("FAIL R2 cfg_flat actual=%h expected=%h", cfg_flat, exp_cfg);
            end
            if (irq_flags !== exp_irq) begin
                fails++;
                $display("FAIL R9 irq_flags actual=%h expected=%h", irq_flags, exp_irq);
            end
        end
    end

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 7; b > 7 - nbits; b--) begin
            spi_mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic txn(input bq_t q, input int tail, input logic [15:0] evt, output bq_t r);
        logic [7:0] v;
        r = {};
        spi_nss = 1'b0;
        repeat (HALF) @(negedge clk);
        foreach (q[i]) begin
            xfer(q[i], 8, v);
            r.push_back(v);
        end
        if (tail > 0) xfer(8'hFF, tail, v);
        repeat (HALF) @(negedge clk);
        spi_nss = 1'b1;
        if (evt != 16'h0) begin
            for (int k = 0; k < 20 && !busy; k++) @(negedge clk);
            irq_evt = evt;
            @(negedge clk);
            irq_evt = '0;
        end
        repeat (6) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // kind: 0 none, 1 register write, 2 buffer write, 3 flag clear
    task automatic cmd(input int kind, input bq_t q, input int tail, input logic [15:0] evt,
                       input int exp_busy, input string tag, output bq_t r);
        int n0;
        int first;
        m_kind = (tail > 0) ? 0 : kind;
        m_data = {};
        first = (kind == 1) ? 3 : 2;
        if (kind == 1) m_base = {q[1], q[2]};
        if (kind == 2) m_base = {8'h00, q[1]};
        if (kind == 3) m_mask = {q[1], q[2]};
        if (kind == 1 || kind == 2)
            for (int i = first; i < q.size() && m_data.size() < STG; i++) m_data.push_back(q[i]);
        n0 = nbusy;
        txn(q, tail, evt, r);
        if (exp_busy == 0) begin
            check(nbusy == n0, tag, "busy pulses", nbusy - n0, 0);
        end else begin
            check(nbusy == n0 + 1, tag, "busy pulses", nbusy - n0, 1);
            check(last_len == exp_busy, tag, "busy length", last_len, exp_busy);
        end
        m_kind = 0;
    endtask

    initial begin
        bq_t r, q;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R10)
        check(busy == 1'b0, "R10", "busy after reset", busy, 0);
        check(irq_flags == 16'h0, "R10", "flags after reset", irq_flags, 0);
        check(cfg_flat == '0, "R10", "cfg after reset", longint'(cfg_flat[63:0]), 0);
        check(spi_miso == 1'b0, "R1", "miso idle", spi_miso, 0);

        // R2 R3: two bytes at 0x06CD land at 0x06CD and 0x06CE
        cmd(1, '{8'h0D, 8'h06, 8'hCD, 8'hAA, 8'h55}, 0, 16'h0, 3, "R3", r);
        check(cfg_flat[13*8 +: 8] == 8'hAA, "R3", "reg 0x06CD", cfg_flat[13*8 +: 8], 8'hAA);
        check(cfg_flat[14*8 +: 8] == 8'h55, "R3", "reg 0x06CE", cfg_flat[14*8 +: 8], 8'h55);
        check(r[0] == 8'h00 && r[3] == 8'h00, "R1", "miso during write", r[3], 0);

        // R2: run crossing the top of the window
        cmd(1, '{8'h0D, 8'h06, 8'hCF, 8'h11, 8'h22, 8'h33}, 0, 16'h0, 4, "R2", r);
        check(cfg_flat[15*8 +: 8] == 8'h11, "R2", "reg 0x06CF", cfg_flat[15*8 +: 8], 8'h11);

        // R13: 18 data bytes, only 16 staged
        q = '{8'h0D, 8'h06, 8'hC0};
        for (int i = 0; i < 18; i++) q.push_back(8'(i + 1));
        cmd(1, q, 0, 16'h0, STG + 1, "R13", r);
        check(cfg_flat[15*8 +: 8] == 8'd16, "R13", "last reg", cfg_flat[15*8 +: 8], 16);
        check(cfg_flat[0 +: 8] == 8'd1, "R13", "first reg", cfg_flat[0 +: 8], 1);

        // R4 R5: buffer write wrapping past 0xFF
        cmd(2, '{8'h0E, 8'hFE, 8'h01, 8'h02, 8'h03, 8'h04}, 0, 16'h0, 5, "R4", r);

        // R5 R6 R4: read it back across the wrap
        cmd(0, '{8'h1E, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0, 16'h0, 1, "R5", r);
        check(r[0] == 8'h00 && r[1] == 8'h00, "R1", "miso opcode/offset", {r[0], r[1]}, 0);
        check(r[2] == {7'b0, |exp_irq}, "R6", "status byte", r[2], {7'b0, |exp_irq});
        for (int i = 0; i < 4; i++)
            check(r[3+i] == exp_buf[8'(8'hFE + i)], "R4", "buffer read", r[3+i], exp_buf[8'(8'hFE + i)]);
        check(r[5] == 8'h03, "R5", "wrapped byte at 0x00", r[5], 3);

        // events then flag read (R7 R6 R9)
        @(negedge clk); irq_evt = 16'h8001;
        @(negedge clk); irq_evt = 16'h0100;
        @(negedge clk); irq_evt = 16'h0000;
        repeat (2) @(negedge clk);
        check(irq_flags == 16'h8101, "R9", "flags after events", irq_flags, 16'h8101);
        cmd(0, '{8'h12, 8'h00, 8'h00, 8'h00}, 0, 16'h0, 1, "R7", r);
        check(r[1] == 8'h01, "R6", "status with flags", r[1], 1);
        check(r[2] == 8'h81, "R7", "flags high byte", r[2], 8'h81);
        check(r[3] == 8'h01, "R7", "flags low byte", r[3], 8'h01);

        // R8: clear bit 15
        cmd(3, '{8'h02, 8'h80, 8'h00}, 0, 16'h0, 1, "R8", r);
        check(irq_flags == 16'h0101, "R8", "after clear", irq_flags, 16'h0101);

        // R9: clear of bit 0 collides with a new event on bit 0
        cmd(3, '{8'h02, 8'h00, 8'h01}, 0, 16'h0001, 1, "R9", r);
        check(irq_flags[0] == 1'b1, "R9", "set beats clear", irq_flags[0], 1);

        // R8: only one mask byte, nothing cleared
        cmd(0, '{8'h02, 8'hFF}, 0, 16'h0, 1, "R8", r);
        check(irq_flags == 16'h0101, "R8", "partial mask", irq_flags, 16'h0101);

        // R11: aborts mid-byte
        cmd(1, '{8'h0D, 8'h06, 8'hC0, 8'hEE}, 3, 16'h0, 0, "R11", r);
        check(cfg_flat[0 +: 8] == 8'd1, "R11", "reg after abort", cfg_flat[0 +: 8], 1);
        cmd(3, '{8'h02, 8'hFF, 8'hFF}, 2, 16'h0, 0, "R11", r);
        check(irq_flags == 16'h0101, "R11", "flags after abort", irq_flags, 16'h0101);

        // R12: unknown opcode
        cmd(0, '{8'h55, 8'h11, 8'h22}, 0, 16'h0, 1, "R12", r);
        check(r[1] == 8'h00 && r[2] == 8'h00, "R12", "miso unknown", {r[1], r[2]}, 0);

        // R6: clear all, status bit drops
        cmd(3, '{8'h02, 8'hFF, 8'hFF}, 0, 16'h0, 1, "R8", r);
        cmd(0, '{8'h12, 8'h00, 8'h00, 8'h00}, 0, 16'h0, 1, "R6", r);
        check(r[1] == 8'h00, "R6", "status clear", r[1], 0);
        check({r[2], r[3]} == 16'h0, "R7", "flags clear", {r[2], r[3]}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule